// File: doc/BRIEF.md
# Rate-Absorbing Serial Byte Repeater

This block takes an asynchronous serial byte stream on one line and sends the same bytes out on a second line. The two sides run from separate 16x oversample ticks. The outgoing bit clock may be slightly slower than the incoming one. Received bytes wait in a small FIFO.

A slower transmitter would let the backlog grow without limit. To prevent this, the transmitter trims the stop bit of each outgoing frame in sixteenth-of-a-bit steps whenever bytes are waiting, so the output keeps pace with the input. A hold-off output asks the upstream sender to pause when the FIFO is nearly full. Sticky flags report dropped bytes and bad stop bits.

Top module: `uart_repeater`

## Requirements
- R1: Outgoing frames use an idle-high line: one low start bit of 16 tx ticks, eight data bits of 16 tx ticks each sent least significant bit first, then a high stop bit. The line stays high while nothing is queued.
- R2: The receiver validates a start bit 8 rx ticks after it first sees the line low. A low pulse that has ended by then is ignored: it produces no byte and no error. Each data bit is sampled 16 rx ticks after the previous sample, and data arrive least significant bit first.
- R3: If the stop-bit sample is low, the byte is dropped and `frame_err` is set. The receiver then waits for the line to return high before it searches for a new start bit.
- R4: Bytes leave in the order they arrived. The FIFO holds up to DEPTH (default 8) bytes.
- R5: A byte that completes while the FIFO is full is dropped and `ovf_flag` is set. The flag stays set until `err_clr` is pulsed. Clearing the flag does not disturb the queued bytes.
- R6: The stop length is chosen when the stop bit begins, from L, the number of bytes still waiting (the byte being sent is not counted). If L <= 1, the stop bit lasts 16 tx ticks. Otherwise it lasts 16 - 2*(L-1) ticks, but never fewer than 8.
- R7: The transmitter advances only on `tx_tick`. When a byte is waiting at the end of a stop bit, the next start bit begins on the very next tick.
- R8: `hold_off` is high exactly while the FIFO holds 7 or more bytes.
- R9: Suppose the input is a continuous stream of full-length frames and the tx tick runs at 31/32 of the rx tick rate. Then no byte is lost and every byte is repeated, with stop bits of at least 8 ticks.
- R10: `err_clr` returns both `frame_err` and `ovf_flag` to low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_tick | input | 1 | 16x oversample enable, receive side |
| tx_tick | input | 1 | 16x oversample enable, transmit side |
| rx_line | input | 1 | Incoming serial line |
| tx_line | output | 1 | Outgoing serial line |
| hold_off | output | 1 | Request to the sender to pause |
| ovf_flag | output | 1 | Sticky: a byte was dropped because the FIFO was full |
| frame_err | output | 1 | Sticky: a stop bit was sampled low |
| err_clr | input | 1 | Clears both sticky flags |

## Verification
The bench fills the FIFO while the tx tick is stopped, then drains it at full speed. It checks each stop length exactly: 8, 8, 8, 10, 12, 14, 16 ticks. An off-by-one in the trim formula, a level count that includes the byte in flight, or a missing clamp would change that sequence. A short low glitch must produce no byte, which catches a receiver that trusts the falling edge alone. A long break after a bad stop bit must not be taken as a fresh start. A ninth byte must raise the overflow flag without evicting queued data. A long run at a 31/32 rate ratio shows whether trimming actually keeps the backlog bounded.

// File: rtl/uart_rep_pkg.sv
package uart_rep_pkg;
   typedef enum logic [2:0] {
      RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_WAITHI
   } rx_state_e;

   typedef enum logic [1:0] {
      TX_IDLE, TX_START, TX_DATA, TX_STOP
   } tx_state_e;
endpackage

// File: rtl/urp_rx.sv
module urp_rx #(
   parameter int OVS = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       line_in,
   output logic       byte_vld,
   output logic [7:0] byte_out,
   output logic       frame_bad
);
   import uart_rep_pkg::*;
   localparam int CW   = $clog2(OVS);
   localparam int HALF = OVS / 2;

   rx_state_e      st;
   logic [CW-1:0]  cnt;
   logic [2:0]     bitn;
   logic [7:0]     sh;
   logic [1:0]     sync;
   logic           ln;

   assign ln       = sync[1];
   assign byte_out = sh;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync <= 2'b11;
      end else begin
         sync <= {sync[0], line_in};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= RX_IDLE;
         cnt       <= '0;
         bitn      <= '0;
         sh        <= '0;
         byte_vld  <= 1'b0;
         frame_bad <= 1'b0;
      end else begin
         byte_vld  <= 1'b0;
         frame_bad <= 1'b0;
         if (tick) begin
            case (st)
               RX_IDLE: if (!ln) begin
                  st  <= RX_START;
                  cnt <= '0;
               end
               RX_START: begin
                  if (cnt == CW'(HALF - 1)) begin
                     cnt  <= '0;
                     bitn <= '0;
                     st   <= ln ? RX_IDLE : RX_DATA;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_DATA: begin
                  if (cnt == CW'(OVS - 1)) begin
                     cnt <= '0;
                     sh  <= {ln, sh[7:1]};
                     if (bitn == 3'd7) st <= RX_STOP;
                     else bitn <= bitn + 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_STOP: begin
                  if (cnt == CW'(OVS - 1)) begin
                     cnt <= '0;
                     if (ln) begin
                        byte_vld <= 1'b1;
                        st       <= RX_IDLE;
                     end else begin
                        frame_bad <= 1'b1;
                        st        <= RX_WAITHI;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: if (ln) st <= RX_IDLE;
            endcase
         end
      end
   end

   // R3
   rx_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(byte_vld && frame_bad));
endmodule

// File: rtl/urp_fifo.sv
module urp_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 8,
   parameter int LW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic [LW-1:0] level,
   output logic          full,
   output logic          empty
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic          do_push, do_pop;

   assign full    = (level == LW'(DEPTH));
   assign empty   = (level == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rp];

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (do_push && wp == AW'(i)) mem[i] <= din;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         level <= '0;
      end else begin
         if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
         if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
         case ({do_push, do_pop})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end

   // R4
   level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LW'(DEPTH));
   // R4
   pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
endmodule

// File: rtl/urp_tx.sv
module urp_tx #(
   parameter int OVS         = 16,
   parameter int MIN_STOP    = 8,
   parameter int TRIM_THRESH = 1,
   parameter int TRIM_STEP   = 2,
   parameter int LW          = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          have_data,
   input  logic [7:0]    din,
   input  logic [LW-1:0] level,
   output logic          pop,
   output logic          line_out
);
   import uart_rep_pkg::*;
   localparam int CW = $clog2(OVS);

   tx_state_e     st;
   logic [CW-1:0] cnt, stop_last, stop_calc;
   logic [2:0]    bitn;
   logic [7:0]    sh;
   logic          stop_end;

   always_comb begin
      int shrink;
      shrink = 0;
      if (int'(level) <= TRIM_THRESH) begin
         stop_calc = CW'(OVS - 1);
      end else begin
         shrink = (int'(level) - TRIM_THRESH) * TRIM_STEP;
         if (shrink >= OVS - MIN_STOP) stop_calc = CW'(MIN_STOP - 1);
         else stop_calc = CW'(OVS - 1 - shrink);
      end
   end

   assign stop_end = (st == TX_STOP) && (cnt == stop_last);
   assign pop      = tick && have_data && ((st == TX_IDLE) || stop_end);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= TX_IDLE;
         cnt       <= '0;
         bitn      <= '0;
         sh        <= '0;
         stop_last <= CW'(OVS - 1);
         line_out  <= 1'b1;
      end else if (tick) begin
         if (pop) begin
            sh       <= din;
            line_out <= 1'b0;
            st       <= TX_START;
            cnt      <= '0;
         end else begin
            case (st)
               TX_START: begin
                  if (cnt == CW'(OVS - 1)) begin
                     line_out <= sh[0];
                     st       <= TX_DATA;
                     cnt      <= '0;
                     bitn     <= '0;
                  end else cnt <= cnt + 1'b1;
               end
               TX_DATA: begin
                  if (cnt == CW'(OVS - 1)) begin
                     cnt <= '0;
                     if (bitn == 3'd7) begin
                        line_out  <= 1'b1;
                        st        <= TX_STOP;
                        stop_last <= stop_calc;
                     end else begin
                        bitn     <= bitn + 1'b1;
                        line_out <= sh[1];
                        sh       <= {1'b0, sh[7:1]};
                     end
                  end else cnt <= cnt + 1'b1;
               end
               TX_STOP: begin
                  if (stop_end) begin
                     cnt <= '0;
                     st  <= TX_IDLE;
                  end else cnt <= cnt + 1'b1;
               end
               default: st <= TX_IDLE;
            endcase
         end
      end
   end

   // R7
   tx_tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(line_out));
   // R6
   stop_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == TX_STOP) |-> (stop_last >= CW'(MIN_STOP - 1)));
   // R1
   stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == TX_STOP) |-> line_out);
endmodule

// File: rtl/uart_repeater.sv
module uart_repeater #(
   parameter int DEPTH       = 8,
   parameter int OVS         = 16,
   parameter int MIN_STOP    = 8,
   parameter int TRIM_THRESH = 1,
   parameter int TRIM_STEP   = 2,
   parameter int HOLD_LEVEL  = 7,
   parameter bit HOLD_EN     = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_tick,
   input  logic tx_tick,
   input  logic rx_line,
   output logic tx_line,
   output logic hold_off,
   output logic ovf_flag,
   output logic frame_err,
   input  logic err_clr
);
   localparam int LW = $clog2(DEPTH + 1);

   if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
      $error("OVS must be even and at least 4");
   end
   if (MIN_STOP < 1 || MIN_STOP > OVS) begin : g_bad_min
      $error("MIN_STOP out of range");
   end
   if (DEPTH < 2 || HOLD_LEVEL > DEPTH) begin : g_bad_depth
      $error("DEPTH or HOLD_LEVEL out of range");
   end

   logic          rx_vld, rx_bad, f_full, f_empty, f_pop;
   logic [7:0]    rx_byte, f_dout;
   logic [LW-1:0] f_level;

   urp_rx #(.OVS(OVS)) u_rx (
      .clk(clk), .rst_n(rst_n), .tick(rx_tick), .line_in(rx_line),
      .byte_vld(rx_vld), .byte_out(rx_byte), .frame_bad(rx_bad)
   );

   urp_fifo #(.W(8), .DEPTH(DEPTH), .LW(LW)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(rx_vld && !f_full), .din(rx_byte),
      .pop(f_pop), .dout(f_dout), .level(f_level), .full(f_full),
      .empty(f_empty)
   );

   urp_tx #(.OVS(OVS), .MIN_STOP(MIN_STOP), .TRIM_THRESH(TRIM_THRESH),
            .TRIM_STEP(TRIM_STEP), .LW(LW)) u_tx (
      .clk(clk), .rst_n(rst_n), .tick(tx_tick), .have_data(!f_empty),
      .din(f_dout), .level(f_level), .pop(f_pop), .line_out(tx_line)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ovf_flag  <= 1'b0;
         frame_err <= 1'b0;
      end else begin
         if (rx_vld && f_full) ovf_flag <= 1'b1;
         else if (err_clr)     ovf_flag <= 1'b0;
         if (rx_bad)           frame_err <= 1'b1;
         else if (err_clr)     frame_err <= 1'b0;
      end
   end

   if (HOLD_EN) begin : g_hold
      assign hold_off = (f_level >= LW'(HOLD_LEVEL));
      // R8
      hold_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
         f_full |-> hold_off);
   end else begin : g_nohold
      assign hold_off = 1'b0;
   end

   // R5
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !err_clr) |=> ovf_flag);
   // R3
   ferr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_err && !err_clr) |=> frame_err);
endmodule

// File: tb/test_uart_repeater.sv
module test_uart_repeater;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_line = 1'b1;
   logic err_clr = 1'b0;
   logic tx_tick = 1'b1;
   logic tx_line, hold_off, ovf_flag, frame_err;

   int n_chk = 0, n_bad = 0;
   int tick_mode = 1;
   int tdiv = 0;
   bit done = 0;

   // decoder state
   int        dst = 0, tc = 0, run = 0;
   bit        have_prev = 0;
   logic [7:0] dsh = '0;
   logic [7:0] got[$];
   int        runs[$];

   always #10 clk = ~clk;

   uart_repeater i_uart_repeater (
      .clk(clk), .rst_n(rst_n), .rx_tick(1'b1), .tx_tick(tx_tick),
      .rx_line(rx_line), .tx_line(tx_line), .hold_off(hold_off),
      .ovf_flag(ovf_flag), .frame_err(frame_err), .err_clr(err_clr)
   );

   always @(negedge clk) begin
      if (tx_tick && rst_n) begin
         if (dst == 0) begin
            if (!tx_line) begin
               if (have_prev) runs.push_back(run);
               dst = 1;
               tc  = 1;
            end else run++;
         end else begin
            tc++;
            if (tc > 16 && (tc % 16) == 8) dsh[(tc / 16) - 1] = tx_line;
            if (tc == 144) begin
               got.push_back(dsh);
               dst = 0;
               run = 0;
               have_prev = 1;
            end
         end
      end
      tdiv = (tdiv + 1) % 32;
      case (tick_mode)
         0: tx_tick = 1'b0;
         2: tx_tick = (tdiv != 31);
         default: tx_tick = 1'b1;
      endcase
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic send_frame(input logic [7:0] b, input bit stop_hi);
      rx_line = 1'b0;
      repeat (16) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         rx_line = b[i];
         repeat (16) @(negedge clk);
      end
      rx_line = stop_hi;
      repeat (16) @(negedge clk);
      rx_line = 1'b1;
   endtask

   task automatic clear_flags();
      err_clr = 1'b1;
      @(negedge clk);
      err_clr = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R1 idle line", tx_line, 1);
      chk("R8 hold at reset", hold_off, 0);
      chk("R5 ovf at reset", ovf_flag, 0);
      chk("R3 ferr at reset", frame_err, 0);
   endtask

   task automatic t_single();
      got.delete();
      send_frame(8'hA5, 1'b1);
      repeat (200) @(negedge clk);
      chk("R1 one byte out", got.size(), 1);
      if (got.size() > 0) chk("R1 data lsb first", got[0], 8'hA5);
      send_frame(8'h01, 1'b1);
      send_frame(8'h80, 1'b1);
      repeat (200) @(negedge clk);
      chk("R4 count", got.size(), 3);
      if (got.size() == 3) begin
         chk("R4 order a", got[1], 8'h01);
         chk("R4 order b", got[2], 8'h80);
      end
      chk("R1 idle after drain", tx_line, 1);
   endtask

   task automatic t_glitch();
      got.delete();
      rx_line = 1'b0;
      repeat (4) @(negedge clk);
      rx_line = 1'b1;
      repeat (300) @(negedge clk);
      chk("R2 glitch no byte", got.size(), 0);
      chk("R2 glitch no error", frame_err, 0);
      send_frame(8'h3C, 1'b1);
      repeat (200) @(negedge clk);
      chk("R2 byte after glitch", got.size(), 1);
      if (got.size() > 0) chk("R2 data", got[0], 8'h3C);
   endtask

   task automatic t_frame();
      got.delete();
      send_frame(8'h55, 1'b0);
      rx_line = 1'b0;
      repeat (40) @(negedge clk);
      rx_line = 1'b1;
      repeat (300) @(negedge clk);
      chk("R3 ferr set", frame_err, 1);
      chk("R3 byte dropped", got.size(), 0);
      clear_flags();
      chk("R10 ferr cleared", frame_err, 0);
      send_frame(8'hC3, 1'b1);
      repeat (200) @(negedge clk);
      chk("R3 recovers", got.size(), 1);
      if (got.size() > 0) chk("R3 data after", got[0], 8'hC3);
   endtask

   task automatic t_fill_drain();
      int exp_run[7] = '{8, 8, 8, 10, 12, 14, 16};
      got.delete();
      runs.delete();
      have_prev = 0;
      tick_mode = 0;
      for (int i = 0; i < 6; i++) send_frame(8'(8'h10 + i), 1'b1);
      repeat (5) @(negedge clk);
      chk("R8 hold below level", hold_off, 0);
      send_frame(8'h16, 1'b1);
      repeat (5) @(negedge clk);
      chk("R8 hold at level", hold_off, 1);
      send_frame(8'h17, 1'b1);
      repeat (5) @(negedge clk);
      chk("R5 full no ovf", ovf_flag, 0);
      send_frame(8'hEE, 1'b1);
      repeat (5) @(negedge clk);
      chk("R5 ovf set", ovf_flag, 1);
      chk("R7 no output without tick", got.size(), 0);
      clear_flags();
      chk("R10 ovf cleared", ovf_flag, 0);
      chk("R5 clear keeps data", hold_off, 1);
      tick_mode = 1;
      repeat (2000) @(negedge clk);
      chk("R5 eight bytes", got.size(), 8);
      for (int i = 0; i < 8 && i < got.size(); i++)
         chk("R4 fill order", got[i], 8'h10 + i);
      chk("R6 stop count", runs.size(), 7);
      for (int i = 0; i < 7 && i < runs.size(); i++)
         chk("R6 stop length", runs[i], exp_run[i]);
      chk("R8 hold released", hold_off, 0);
   endtask

   task automatic t_mismatch();
      int minr = 1000;
      got.delete();
      runs.delete();
      have_prev = 0;
      tick_mode = 2;
      for (int i = 0; i < 100; i++) send_frame(8'((i * 37) + 5), 1'b1);
      for (int w = 0; w < 4000 && got.size() < 100; w++) @(negedge clk);
      chk("R9 all bytes", got.size(), 100);
      chk("R9 no overflow", ovf_flag, 0);
      for (int i = 0; i < 100 && i < got.size(); i++)
         if (got[i] != 8'((i * 37) + 5)) chk("R9 data", got[i], 8'((i * 37) + 5));
      foreach (runs[i]) if (runs[i] < minr) minr = runs[i];
      chk("R9 stop floor", (minr >= 8) ? 1 : 0, 1);
      chk("R9 stop trimmed", (minr < 16) ? 1 : 0, 1);
      tick_mode = 1;
   endtask

   initial begin
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      t_single();
      t_glitch();
      t_frame();
      t_fill_drain();
      t_mismatch();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule